// File: doc/BRIEF.md
# Dual-Geometry SDRAM Address Sequencer

This block generates the address and command side of one SDRAM access for a 72-bit module that mixes two device geometries on one shared address bus. The first device type has four banks and uses 12 row bits, 8 column bits and 2 bank bits. The second type has two banks and uses 11 row bits, 10 column bits and 1 bank bit. A request strobe comes with a flat word address and a write flag. The block then issues an activate command with the row word, waits a fixed number of idle cycles, issues a read or write command with the column word, and finally pulses a completion flag.

The column word contains more than the column itself, so that both device types decode it correctly. The top row bit is sent again on the first spare column line above the true column bits. The upper bank bit is sent again on the line above that, where the two-bank device reads it as a column bit. Any access that opens the upper bank pair must close its row after the burst. For such an access the block raises the auto-precharge line during the column command.

A page is 256 columns deep, which is the depth of the device with the fewest columns. The flat address is therefore split, from the least significant bit upward, into 8 column bits, 2 bank bits and 12 row bits.

Top module: `sdram_addr_mux`

## Requirements
- R1: While reset is asserted, the command lines are NOP (RAS/CAS/WE = 1/1/1), A and BA are zero, and done is low.
- R2: The flat address is split as column = bits 7:0, bank = bits 9:8 and row = bits 21:10.
- R3: A strobe sampled while the block is idle produces an activate command (RAS/CAS/WE = 0/1/1) on the next output cycle. During that cycle A[11:0] carries the row, A[13:12] are low and BA carries the bank.
- R4: Between the activate and the column command there are exactly RCD_CYCLES output cycles (default 2). Each of them is a NOP with A and BA at zero.
- R5: The column command is a read (1/0/1) when the write flag was low at acceptance and a write (1/0/0) when it was high. A[7:0] carries the column. RAS and CAS are never low together.
- R6: During the column command, A8 carries row bit 11.
- R7: During the column command, A9 carries bank bit 1.
- R8: During the column command, A10 (auto-precharge) equals bank bit 1, so it is high exactly when the upper bank pair was opened.
- R9: BA carries the same value during the column command as during the activate of that access.
- R10: During the column command, A[13:11] are low.
- R11: The done output is high for exactly one cycle, in the cycle that follows the column command.
- R12: A strobe that arrives while an access is in progress is ignored. The next strobe is accepted when it is sampled in the cycle in which done is high or in any later idle cycle.
- R13: Outside an access sequence, the outputs are NOP, A and BA are zero, and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request strobe |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| addr_i | input | 22 | Flat word address |
| a_o | output | 14 | Multiplexed address lines A[13:0] |
| ba_o | output | 2 | Bank address lines |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every output is registered once. The activate therefore appears after the same rising edge that samples an idle-state strobe. The column command follows RCD_CYCLES+1 edges later, and done follows one edge after the column command. The reference model works out, for each rising edge, which output cycle is due: it queues the whole beat sequence of an access at the edge that accepts the strobe and removes one beat per edge. The bench compares the outputs on the falling edge, half a period after the edge that updated them, so every comparison sees the value registered in that cycle.

// File: rtl/sdram_amux_pkg.sv
package sdram_amux_pkg;

    // Active-low command encodings on {RAS, CAS, WE}
    typedef enum logic [2:0] {
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_NOP = 3'b111
    } sdr_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_FIN
    } seq_state_e;

endpackage

// File: rtl/amux_split.sv
module amux_split #(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    localparam int FLAT_W = COL_W + BANK_W + ROW_W
) (
    input  logic [FLAT_W-1:0] flat_i,
    output logic [COL_W-1:0]  col_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o
);
    // LSB upward: column, bank, row (R2)
    assign col_o  = flat_i[COL_W-1:0];
    assign bank_o = flat_i[COL_W+BANK_W-1:COL_W];
    assign row_o  = flat_i[FLAT_W-1:COL_W+BANK_W];
endmodule

// File: rtl/amux_rowmap.sv
module amux_rowmap #(
    parameter int ROW_W  = 12,
    parameter int ADDR_W = 14
) (
    input  logic [ROW_W-1:0]  row_i,
    output logic [ADDR_W-1:0] a_o
);
    // Row lines beyond the configured row width are held low
    for (genvar i = 0; i < ADDR_W; i++) begin : g_line
        if (i < ROW_W) begin : g_used
            assign a_o[i] = row_i[i];
        end else begin : g_unused
            assign a_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/amux_colmap.sv
module amux_colmap #(
    parameter int COL_W  = 8,
    parameter int ADDR_W = 14,
    parameter int AP_BIT = 10
) (
    input  logic [COL_W-1:0]  col_i,
    input  logic              row_top_i,
    input  logic              bank_top_i,
    output logic [ADDR_W-1:0] a_o
);
    // Spare column lines carry the extra geometry bits of the narrower-page device
    for (genvar i = 0; i < ADDR_W; i++) begin : g_line
        if (i < COL_W) begin : g_col
            assign a_o[i] = col_i[i];
        end else if (i == COL_W) begin : g_row_echo
            assign a_o[i] = row_top_i;
        end else if (i == COL_W + 1) begin : g_bank_echo
            assign a_o[i] = bank_top_i;
        end else if (i == AP_BIT) begin : g_autopre
            assign a_o[i] = bank_top_i;
        end else begin : g_zero
            assign a_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sdram_addr_mux.sv
module sdram_addr_mux
    import sdram_amux_pkg::*;
#(
    parameter int COL_W      = 8,
    parameter int BANK_W     = 2,
    parameter int ROW_W      = 12,
    parameter int ADDR_W     = 14,
    parameter int AP_BIT     = 10,
    parameter int RCD_CYCLES = 2,
    localparam int FLAT_W    = COL_W + BANK_W + ROW_W,
    localparam int CNT_W     = (RCD_CYCLES < 1) ? 1 : $clog2(RCD_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [FLAT_W-1:0] addr_i,
    output logic [ADDR_W-1:0] a_o,
    output logic [BANK_W-1:0] ba_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic              done_o
);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic              row_top;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [ADDR_W-1:0] a;
        logic [BANK_W-1:0] ba;
        sdr_cmd_e          cmd;
        logic              done;
    } seq_t;

    localparam seq_t SEQ_RST = '{ST_IDLE, '0, 1'b0, 1'b0, '0, '0, '0, '0, CMD_NOP, 1'b0};

    seq_t seq_d, seq_q;

    logic [COL_W-1:0]  in_col;
    logic [BANK_W-1:0] in_bank;
    logic [ROW_W-1:0]  in_row;
    logic [ADDR_W-1:0] row_word;
    logic [ADDR_W-1:0] col_word;

    amux_split #(
        .COL_W  (COL_W),
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) i_split (
        .flat_i (addr_i),
        .col_o  (in_col),
        .bank_o (in_bank),
        .row_o  (in_row)
    );

    amux_rowmap #(
        .ROW_W  (ROW_W),
        .ADDR_W (ADDR_W)
    ) i_rowmap (
        .row_i (in_row),
        .a_o   (row_word)
    );

    amux_colmap #(
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W),
        .AP_BIT (AP_BIT)
    ) i_colmap (
        .col_i      (seq_q.col),
        .row_top_i  (seq_q.row_top),
        .bank_top_i (seq_q.bank[BANK_W-1]),
        .a_o        (col_word)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.cmd  = CMD_NOP;
        seq_d.a    = '0;
        seq_d.ba   = '0;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    seq_d.state   = ST_GAP;
                    seq_d.cnt     = CNT_W'(RCD_CYCLES);
                    seq_d.wr      = wr_i;
                    seq_d.row_top = in_row[ROW_W-1];
                    seq_d.bank    = in_bank;
                    seq_d.col     = in_col;
                    seq_d.cmd     = CMD_ACT;
                    seq_d.a       = row_word;
                    seq_d.ba      = in_bank;
                end
            end
            ST_GAP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = ST_FIN;
                    seq_d.cmd   = seq_q.wr ? CMD_WR : CMD_RD;
                    seq_d.a     = col_word;
                    seq_d.ba    = seq_q.bank;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_FIN: begin
                seq_d.state = ST_IDLE;
                seq_d.done  = 1'b1;
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign a_o     = seq_q.a;
    assign ba_o    = seq_q.ba;
    assign ras_n_o = seq_q.cmd[2];
    assign cas_n_o = seq_q.cmd[1];
    assign we_n_o  = seq_q.cmd[0];
    assign done_o  = seq_q.done;

endmodule

// File: rtl/amux_checker.sv
module amux_checker #(
    parameter int COL_W      = 8,
    parameter int BANK_W     = 2,
    parameter int ROW_W      = 12,
    parameter int ADDR_W     = 14,
    parameter int AP_BIT     = 10,
    parameter int RCD_CYCLES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic [ADDR_W-1:0] a_o,
    input logic [BANK_W-1:0] ba_o,
    input logic              ras_n_o,
    input logic              cas_n_o,
    input logic              we_n_o,
    input logic              done_o
);
    logic              act_seen;
    logic              col_seen;
    logic [7:0]        gap_cnt;
    logic [BANK_W-1:0] ba_at_act;

    assign act_seen = !ras_n_o && cas_n_o && we_n_o;
    assign col_seen = ras_n_o && !cas_n_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt   <= '0;
            ba_at_act <= '0;
        end else if (act_seen) begin
            gap_cnt   <= 8'd1;
            ba_at_act <= ba_o;
        end else if (gap_cnt != 8'hFF) begin
            gap_cnt <= gap_cnt + 8'd1;
        end
    end

    p_act_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_seen |-> $past(req_i));
    p_act_high_rows_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_seen |-> ((a_o >> ROW_W) == '0));
    p_rcd_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        col_seen |-> (gap_cnt == 8'(RCD_CYCLES + 1)));
    p_no_cmd_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ras_n_o && !cas_n_o));
    p_bank_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        col_seen |-> (a_o[COL_W+1] == ba_o[BANK_W-1]));
    p_autopre_r8: assert property (@(posedge clk) disable iff (!rst_n)
        col_seen |-> (a_o[AP_BIT] == ba_o[BANK_W-1]));
    p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        col_seen |-> (ba_o == ba_at_act));
    p_done_after_col_r11: assert property (@(posedge clk) disable iff (!rst_n)
        col_seen |=> done_o);
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ras_n_o && cas_n_o && we_n_o && (a_o == '0)));
endmodule

bind sdram_addr_mux amux_checker #(
    .COL_W      (COL_W),
    .BANK_W     (BANK_W),
    .ROW_W      (ROW_W),
    .ADDR_W     (ADDR_W),
    .AP_BIT     (AP_BIT),
    .RCD_CYCLES (RCD_CYCLES)
) i_amux_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .a_o     (a_o),
    .ba_o    (ba_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .done_o  (done_o)
);

// File: tb/test_sdram_addr_mux.sv
`timescale 1ns/1ps
module test_sdram_addr_mux;

    localparam int RCD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [21:0] addr_i = '0;
    logic [13:0] a_o;
    logic [1:0]  ba_o;
    logic        ras_n_o, cas_n_o, we_n_o, done_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sdram_addr_mux i_sdram_addr_mux (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
        .a_o(a_o), .ba_o(ba_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
        .we_n_o(we_n_o), .done_o(done_o)
    );

    // kind: 0 idle, 1 activate, 2 gap, 3 column, 4 done
    typedef struct {
        logic [13:0] a;
        logic [1:0]  ba;
        logic [2:0]  cmd;
        logic        done;
        int          kind;
    } beat_t;

    beat_t q[$];
    beat_t exp_b;

    function automatic beat_t mk(int a, int ba, logic [2:0] cmd, logic dn, int kind);
        beat_t b;
        b.a = 14'(a); b.ba = 2'(ba); b.cmd = cmd; b.done = dn; b.kind = kind;
        return b;
    endfunction

    // Behavioural reference: whole access queued when accepted, one beat per edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            exp_b = mk(0, 0, 3'b111, 1'b0, 0);
        end else begin
            if (q.size() == 0 && req_i) begin
                int col, bank, row, colw;
                col  = int'(addr_i) % 256;
                bank = (int'(addr_i) / 256) % 4;
                row  = int'(addr_i) / 1024;
                colw = col + ((row / 2048) * 256) + ((bank / 2) * 512) + ((bank / 2) * 1024);
                q.push_back(mk(row, bank, 3'b011, 1'b0, 1));
                for (int k = 0; k < RCD; k++) q.push_back(mk(0, 0, 3'b111, 1'b0, 2));
                q.push_back(mk(colw, bank, wr_i ? 3'b100 : 3'b101, 1'b0, 3));
                q.push_back(mk(0, 0, 3'b111, 1'b1, 4));
            end
            if (q.size() > 0) exp_b = q.pop_front();
            else exp_b = mk(0, 0, 3'b111, 1'b0, 0);
        end
    end

    task automatic chk(string tag, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic string tag_for(int kind);
        case (kind)
            1: return "R2 R3 activate";
            2: return "R4 gap";
            3: return "R5 column";
            4: return "R11 done";
            default: return "R13 idle";
        endcase
    endfunction

    // Compare half a period after each active edge
    always @(negedge clk) begin
        if (rst_n) begin
            string t;
            t = tag_for(exp_b.kind);
            chk({t, " cmd"}, int'({ras_n_o, cas_n_o, we_n_o}), int'(exp_b.cmd));
            chk("R11 done", int'(done_o), int'(exp_b.done));
            if (exp_b.kind == 3) begin
                chk("R5 col bits", int'(a_o[7:0]), int'(exp_b.a[7:0]));
                chk("R6 row echo A8", int'(a_o[8]), int'(exp_b.a[8]));
                chk("R7 bank echo A9", int'(a_o[9]), int'(exp_b.a[9]));
                chk("R8 autoprecharge A10", int'(a_o[10]), int'(exp_b.a[10]));
                chk("R10 upper lines", int'(a_o[13:11]), 0);
                chk("R9 bank hold", int'(ba_o), int'(exp_b.ba));
            end else begin
                chk({t, " addr"}, int'(a_o), int'(exp_b.a));
                chk({t, " bank"}, int'(ba_o), int'(exp_b.ba));
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic issue(logic [21:0] ad, logic w);
        @(negedge clk);
        req_i = 1'b1; addr_i = ad; wr_i = w;
        @(negedge clk);
        req_i = 1'b0;
        repeat (RCD + 6) @(negedge clk);
    endtask

    function automatic logic [21:0] pack(logic [11:0] row, logic [1:0] bank, logic [7:0] col);
        return {row, bank, col};
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: sequence hung actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        chk("R1 reset cmd", int'({ras_n_o, cas_n_o, we_n_o}), 7);
        chk("R1 reset addr", int'(a_o), 0);
        chk("R1 reset bank", int'(ba_o), 0);
        chk("R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        issue(pack(12'h123, 2'b00, 8'h45), 1'b0);   // lower bank pair, read
        issue(pack(12'h800, 2'b10, 8'h3C), 1'b1);   // upper pair, row top set, write
        issue(pack(12'hFFF, 2'b01, 8'hFF), 1'b1);   // row top set, BA1 low
        issue(pack(12'h000, 2'b11, 8'h00), 1'b0);   // BA1 high, zero row/col
        issue(22'h0, 1'b1);
        issue(22'h3FFFFF, 1'b0);

        // R12: strobe during an access is ignored
        begin
            logic [21:0] first_ad;
            logic found;
            first_ad = pack(12'h5A5, 2'b01, 8'h96);
            found = 1'b0;
            @(negedge clk);
            req_i = 1'b1; addr_i = first_ad; wr_i = 1'b0;
            @(negedge clk);
            req_i = 1'b0;
            @(negedge clk);
            req_i = 1'b1; addr_i = pack(12'h0F0, 2'b10, 8'h11); wr_i = 1'b1;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                req_i = 1'b0;
                if (!found && ras_n_o && !cas_n_o) begin
                    found = 1'b1;
                    chk("R12 column of first request", int'(a_o[7:0]), 'h96);
                    chk("R12 read kept from first request", int'(we_n_o), 1);
                end
            end
            chk("R12 column command seen", int'(found), 1);
            chk("R12 no second activate", int'(ras_n_o), 1);
        end

        // R12: held strobe is re-accepted back to back
        @(negedge clk);
        req_i = 1'b1; addr_i = pack(12'hA5A, 2'b11, 8'h7E); wr_i = 1'b1;
        repeat (4 * (RCD + 3) + 1) @(negedge clk);
        req_i = 1'b0;
        repeat (RCD + 8) @(negedge clk);

        finish_run();
    end

endmodule